// File: doc/BRIEF.md
# Hierarchical Route Selector

This block picks an output direction for a packet in a mesh switch, using two small hop-count tables in place of one table with a row for every destination. The mesh of `MESH_N x MESH_N` nodes is split into equal square sub-regions of side `REG_SIDE`. Each switch holds a local table with one row per node of its own sub-region and a region table with one row per sub-region. A row holds four hop estimates, one per output direction.

For each lookup the block works out which sub-region the destination coordinates fall in and compares it with the switch's own sub-region. If they match, the row comes from the local table, indexed by the destination's offset inside the sub-region. If they differ, the row comes from the region table, indexed by sub-region number. The direction with the fewest hops wins. Ties go to the lower stress value, and remaining ties are broken in the fixed order north, east, south, west. The result names the table and row it came from, so that later learning feedback can be sent back to the same entry.

Feedback comes through the update port. A neighbour reports its own minimum hop count, and the block stores one more than that value, saturating, into the chosen direction of the named row.

Top module: `hier_route_sel`

## Requirements
- R1: After reset, every entry of both tables holds the all-ones hop value (31 for `HOP_W`=5), and `rsp_valid` is 0.
- R2: A destination is in another region when `dst_x / REG_SIDE` differs from `own_x / REG_SIDE` or `dst_y / REG_SIDE` differs from `own_y / REG_SIDE`. `rsp_region` is 1 exactly in that case.
- R3: For a destination in the own region, the local table row `(dst_y mod REG_SIDE) * REG_SIDE + (dst_x mod REG_SIDE)` is used. That row index is reported on `rsp_row`.
- R4: For a destination in another region, the region table row `(dst_y / REG_SIDE) * (MESH_N / REG_SIDE) + (dst_x / REG_SIDE)` is used. That row index is reported on `rsp_row`.
- R5: An update writes `upd_nbr_min + 1` into direction `upd_dir` of row `upd_row` of the table chosen by `upd_region` (1 = region table). The stored value saturates at the all-ones value.
- R6: The selected direction is the one whose entry holds the smallest hop count. That count is reported on `rsp_hops`.
- R7: Among directions with equal smallest hop count, the one with the lowest stress value wins. Stress for direction d is `req_stress[d*STRESS_W +: STRESS_W]`.
- R8: When both hop count and stress are equal, the earliest direction in the order N, E, S, W wins. Direction codes on `rsp_dir` and `upd_dir` are N=0, E=1, S=2, W=3.
- R9: A request sampled with `req_valid` high produces `rsp_valid` high on the next clock edge. `rsp_valid` is low after any edge where `req_valid` was low.
- R10: If a lookup and an update reach the same clock edge, the lookup reads the table contents as they were before that update.
- R11: A region-table update whose `upd_row` is not below the number of regions changes no entry.
- R12: An update to one table leaves the other table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_x | input | $clog2(MESH_N) | Column of this switch |
| own_y | input | $clog2(MESH_N) | Row of this switch |
| req_valid | input | 1 | Lookup request strobe |
| dst_x | input | $clog2(MESH_N) | Destination column |
| dst_y | input | $clog2(MESH_N) | Destination row |
| req_stress | input | 4*STRESS_W | Stress value per direction, N in the lowest field |
| upd_valid | input | 1 | Table update strobe |
| upd_region | input | 1 | 1 selects the region table, 0 the local table |
| upd_row | input | ROW_W | Row to update |
| upd_dir | input | 2 | Direction entry to update |
| upd_nbr_min | input | HOP_W | Neighbour's minimum hop count |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_dir | output | 2 | Chosen direction |
| rsp_region | output | 1 | 1 when the region table was used |
| rsp_row | output | ROW_W | Row that was read |
| rsp_hops | output | HOP_W | Hop count of the chosen direction |

## Verification
The hardest case to reach from the ports is a lookup that meets an update to the same row on the same edge. Only then does the read-before-write order show. The bench drives both strobes in one cycle, expects the old hop count, and then looks the row up again to see the new one. The bench also aims an out-of-range region update at a row number that would alias onto region 0 if its upper bits were dropped. A later lookup of region 0 exposes any such aliasing through its hop count. Saturation is reached by feeding neighbour minima at and just below the all-ones value.

// File: rtl/hier_route_sel.sv
module hier_route_sel #(
  parameter int MESH_N   = 8,
  parameter int REG_SIDE = 4,
  parameter int HOP_W    = 5,
  parameter int STRESS_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(MESH_N)-1:0] own_x,
  input  logic [$clog2(MESH_N)-1:0] own_y,
  input  logic                    req_valid,
  input  logic [$clog2(MESH_N)-1:0] dst_x,
  input  logic [$clog2(MESH_N)-1:0] dst_y,
  input  logic [4*STRESS_W-1:0]   req_stress,
  input  logic                    upd_valid,
  input  logic                    upd_region,
  input  logic [((2*$clog2(REG_SIDE)) > $clog2((MESH_N/REG_SIDE)*(MESH_N/REG_SIDE)+1) ? (2*$clog2(REG_SIDE)) : $clog2((MESH_N/REG_SIDE)*(MESH_N/REG_SIDE)+1))-1:0] upd_row,
  input  logic [1:0]              upd_dir,
  input  logic [HOP_W-1:0]        upd_nbr_min,
  output logic                    rsp_valid,
  output logic [1:0]              rsp_dir,
  output logic                    rsp_region,
  output logic [((2*$clog2(REG_SIDE)) > $clog2((MESH_N/REG_SIDE)*(MESH_N/REG_SIDE)+1) ? (2*$clog2(REG_SIDE)) : $clog2((MESH_N/REG_SIDE)*(MESH_N/REG_SIDE)+1))-1:0] rsp_row,
  output logic [HOP_W-1:0]        rsp_hops
);

  localparam int CW     = $clog2(MESH_N);
  localparam int SH     = $clog2(REG_SIDE);
  localparam int RPL    = MESH_N / REG_SIDE;
  localparam int NREG   = RPL * RPL;
  localparam int LROWS  = REG_SIDE * REG_SIDE;
  localparam int LIDX_W = 2 * SH;
  localparam int RIDX_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int ROW_W  = (LIDX_W > $clog2(NREG + 1)) ? LIDX_W : $clog2(NREG + 1);
  localparam logic [HOP_W-1:0] HOP_MAX = '1;

  logic [HOP_W-1:0] loc_tab [LROWS][4];
  logic [HOP_W-1:0] reg_tab [NREG][4];

  logic [CW-1:0]     dst_rx, dst_ry;
  logic              far_dst;
  logic [LIDX_W-1:0] loc_idx;
  logic [RIDX_W-1:0] reg_idx;
  logic [HOP_W-1:0]  rd_hop [4];
  logic [1:0]        best;
  logic [HOP_W-1:0]  upd_hop;
  logic              loc_we, reg_we;

  assign dst_rx  = dst_x >> SH;
  assign dst_ry  = dst_y >> SH;
  assign far_dst = (dst_rx != (own_x >> SH)) || (dst_ry != (own_y >> SH));
  assign loc_idx = {dst_y[SH-1:0], dst_x[SH-1:0]};
  assign reg_idx = RIDX_W'(int'(dst_ry) * RPL + int'(dst_rx));

  always_comb begin
    for (int d = 0; d < 4; d++)
      rd_hop[d] = far_dst ? reg_tab[reg_idx][d] : loc_tab[loc_idx][d];
  end

  always_comb begin
    best = 2'd0;
    for (int d = 1; d < 4; d++)
      if ({rd_hop[d], req_stress[d*STRESS_W +: STRESS_W]} <
          {rd_hop[best], req_stress[int'(best)*STRESS_W +: STRESS_W]})
        best = 2'(d);
  end

  assign upd_hop = (upd_nbr_min == HOP_MAX) ? HOP_MAX : upd_nbr_min + 1'b1;
  assign loc_we  = upd_valid && !upd_region && (int'(upd_row) < LROWS);
  assign reg_we  = upd_valid &&  upd_region && (int'(upd_row) < NREG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < LROWS; r++)
        for (int d = 0; d < 4; d++) loc_tab[r][d] <= HOP_MAX;
      for (int r = 0; r < NREG; r++)
        for (int d = 0; d < 4; d++) reg_tab[r][d] <= HOP_MAX;
    end else begin
      if (loc_we) loc_tab[LIDX_W'(upd_row)][upd_dir] <= upd_hop;
      if (reg_we) reg_tab[RIDX_W'(upd_row)][upd_dir] <= upd_hop;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_dir    <= 2'd0;
      rsp_region <= 1'b0;
      rsp_row    <= '0;
      rsp_hops   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_dir    <= best;
        rsp_region <= far_dst;
        rsp_row    <= far_dst ? ROW_W'(reg_idx) : ROW_W'(loc_idx);
        rsp_hops   <= rd_hop[best];
      end
    end
  end

  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R9
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R2
  region_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_region == $past(((dst_x / REG_SIDE) != (own_x / REG_SIDE)) ||
                                      ((dst_y / REG_SIDE) != (own_y / REG_SIDE))));

  // R5
  hop_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_hops != '0);

  // R4
  region_row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_region |-> int'(rsp_row) < NREG);

endmodule

// File: tb/tb_hier_route_sel.sv
`timescale 1ns/1ps
module tb_hier_route_sel;
  logic clk = 0, rst_n = 0;
  logic [2:0] own_x = 3'd5, own_y = 3'd2;
  logic req_valid = 0;
  logic [2:0] dst_x = 0, dst_y = 0;
  logic [15:0] req_stress = 0;
  logic upd_valid = 0, upd_region = 0;
  logic [3:0] upd_row = 0;
  logic [1:0] upd_dir = 0;
  logic [4:0] upd_nbr_min = 0;
  logic rsp_valid, rsp_region;
  logic [1:0] rsp_dir;
  logic [3:0] rsp_row;
  logic [4:0] rsp_hops;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hier_route_sel dut (.*);

  localparam int NV = 13;
  // {dst_x, dst_y, stress W S E N, exp_dir, exp_region, exp_row, exp_hops}
  localparam logic [33:0] VEC [NV] = '{
    {3'd6, 3'd1, 16'h0000, 2'd1, 1'b0, 4'd6,  5'd2},
    {3'd7, 3'd6, 16'h0035, 2'd1, 1'b1, 4'd3,  5'd3},
    {3'd7, 3'd6, 16'h0031, 2'd0, 1'b1, 4'd3,  5'd3},
    {3'd1, 3'd1, 16'h0000, 2'd0, 1'b1, 4'd0,  5'd31},
    {3'd1, 3'd1, 16'h1122, 2'd2, 1'b1, 4'd0,  5'd31},
    {3'd4, 3'd0, 16'h0000, 2'd0, 1'b0, 4'd0,  5'd31},
    {3'd7, 3'd3, 16'h0000, 2'd1, 1'b0, 4'd15, 5'd30},
    {3'd5, 3'd1, 16'h0000, 2'd2, 1'b0, 4'd5,  5'd1},
    {3'd5, 3'd2, 16'h0000, 2'd0, 1'b0, 4'd9,  5'd31},
    {3'd6, 3'd0, 16'h0000, 2'd0, 1'b0, 4'd2,  5'd31},
    {3'd0, 3'd5, 16'h0000, 2'd1, 1'b1, 4'd2,  5'd4},
    {3'd4, 3'd4, 16'h0000, 2'd0, 1'b1, 4'd3,  5'd3},
    {3'd3, 3'd2, 16'h0000, 2'd0, 1'b1, 4'd0,  5'd31}
  };
  string vtag [NV];

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic upd(bit reg_sel, int row, int dir, int nbr);
    @(negedge clk);
    upd_valid = 1; upd_region = reg_sel; upd_row = 4'(row);
    upd_dir = 2'(dir); upd_nbr_min = 5'(nbr);
    @(negedge clk);
    upd_valid = 0;
  endtask

  task automatic look(logic [2:0] x, logic [2:0] y, logic [15:0] s,
                      int edir, int ereg, int erow, int ehops, string tag);
    @(negedge clk);
    req_valid = 1; dst_x = x; dst_y = y; req_stress = s;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " R9 valid"}, rsp_valid, 1);
    chk({tag, " dir"}, rsp_dir, edir);
    chk({tag, " region"}, rsp_region, ereg);
    chk({tag, " row"}, rsp_row, erow);
    chk({tag, " hops"}, rsp_hops, ehops);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    vtag = '{"R3 R6", "R4 R7", "R7", "R8 R11", "R8 R7", "R3 R1", "R5",
             "R6 R3", "R3 own", "R12", "R12 R4", "R2 y-edge", "R2 x-edge"};
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid after reset", rsp_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rsp_valid idle", rsp_valid, 0);
    look(3'd6, 3'd1, 16'h0, 0, 0, 6, 31, "R1 initial entry");

    upd(0, 6, 0, 4); upd(0, 6, 1, 1); upd(0, 6, 2, 3); upd(0, 6, 3, 5);
    upd(1, 3, 0, 2); upd(1, 3, 1, 2); upd(1, 3, 2, 7);
    upd(0, 15, 3, 31); upd(0, 15, 0, 30); upd(0, 15, 1, 29); // R5 saturation
    upd(0, 5, 2, 0);
    upd(1, 2, 1, 3);                                         // R12 region only
    upd(1, 4, 2, 0);                                         // R11 out of range

    for (int i = 0; i < NV; i++)
      look(VEC[i][33:31], VEC[i][30:28], VEC[i][27:12], VEC[i][11:10],
           VEC[i][9], VEC[i][8:5], VEC[i][4:0], vtag[i]);

    // R10: lookup and update to the same entry on one edge
    @(negedge clk);
    req_valid = 1; dst_x = 3'd6; dst_y = 3'd1; req_stress = 16'h0;
    upd_valid = 1; upd_region = 0; upd_row = 4'd6; upd_dir = 2'd0; upd_nbr_min = 5'd0;
    @(negedge clk);
    req_valid = 0; upd_valid = 0;
    chk("R10 old dir", rsp_dir, 1);
    chk("R10 old hops", rsp_hops, 2);
    @(negedge clk);
    chk("R9 valid drops", rsp_valid, 0);
    look(3'd6, 3'd1, 16'h0, 0, 0, 6, 1, "R10 new entry");
    finish_run();
  end
endmodule